// File: doc/BRIEF.md
# Per-Channel Timestamp Conditioner

This block cleans up a stream of 56-bit timestamps, each tagged with the input channel that produced it. It sits ahead of any correlation logic. Each channel has its own signed skew correction, which makes up for differences in cable length. Each channel also has its own hold-off window, which throws away the echoes a badly terminated line produces after a real hit. Every timestamp that survives can then be expressed relative to the latest hit on one chosen reference channel. With no reference chosen, times stay counted from the start of the acquisition.

Software programs the windows, the skews and the reference choice through a small write port, and only while acquisition is stopped. Raising the acquisition enable starts a fresh run. Hits are accepted one per clock. A hit that is kept appears at the output two clock edges after it was presented.

Top module: `tsc_conditioner`

## Requirements
- R1: A hit presented with `in_valid` high while `acq_active` is high, and not dropped, shows up with `out_valid` high, with the same channel number, after exactly two rising clock edges.
- R2: When `acq_active` is low, `in_valid` is ignored and no output is produced.
- R3: The skew of the hit's channel is added to the timestamp modulo 2^56 before any other processing. The skew is a 16-bit two's-complement value, sign-extended.
- R4: A hit is dropped when its skewed time minus the skewed time of the last kept hit on the same channel (modulo 2^56) is less than that channel's hold-off value. A difference equal to the hold-off value is kept. The first hit on a channel in a run is always kept.
- R5: A dropped hit does not restart the hold-off window of its channel.
- R6: The hold-off window and history of one channel have no effect on hits of any other channel.
- R7: While no reference is enabled, the output time equals the skewed time.
- R8: While a reference is enabled, a kept hit on the reference channel is stored and is emitted with time 0. A kept hit on any other channel is emitted with its skewed time minus the stored reference time, modulo 2^56.
- R9: While a reference is enabled and no reference hit has been kept since the run started, kept hits on other channels are dropped.
- R10: Configuration writes (`cfg_we` high for one cycle) are ignored while `acq_active` is high. `cfg_sel` chooses the target. Value 0 writes the hold-off of channel `cfg_chan` from `cfg_data[15:0]`. Value 1 writes the skew of channel `cfg_chan` from `cfg_data[15:0]`. Value 2 writes the reference: `cfg_data[3]` enables it and `cfg_data[2:0]` gives its channel.
- R11: A rising edge of `acq_active` clears the hold-off history of every channel and the stored reference.
- R12: After reset, every hold-off is 0, every skew is 0, no reference is enabled and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_active | input | 1 | Acquisition enable; a rising edge starts a run |
| in_valid | input | 1 | Input hit strobe |
| in_chan | input | 3 | Channel of the input hit |
| in_time | input | 56 | Raw timestamp of the input hit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 hold-off, 1 skew, 2 reference |
| cfg_chan | input | 3 | Channel addressed by a hold-off or skew write |
| cfg_data | input | 16 | Configuration write value |
| out_valid | output | 1 | Output hit strobe |
| out_chan | output | 3 | Channel of the output hit |
| out_time | output | 56 | Conditioned timestamp |

## Verification
The bench probes the edges of the hold-off window. It sends a hit exactly at the window length, which a design comparing with the wrong inequality would lose. It also sends a hit just after a dropped echo, which a design that restarted the window on dropped hits would also throw away. Negative skews that wrap below zero, and other-channel hits that come before or behind the reference hit, show whether the subtraction wraps correctly and whether hits with no reference are held back rather than passed through raw. Writes attempted during a run, and a run restarted shortly after a kept hit, expose a design that lets configuration change mid-run or that keeps stale history from the run before.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int TS_W = 56;

    typedef logic [TS_W-1:0] ts_t;

    typedef enum logic [1:0] {
        CFG_HOLDOFF = 2'd0,
        CFG_SKEW    = 2'd1,
        CFG_REF     = 2'd2
    } cfg_sel_e;

    typedef struct packed {
        logic valid;
        ts_t  stamp;
    } stamp_t;

    function automatic ts_t ts_elapsed(ts_t later, ts_t earlier);
        return later - earlier;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tsc_cfg_bank.sv
module tsc_cfg_bank
    import tsc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int DT_W  = 16,
    parameter int OFS_W = 16,
    parameter int CFG_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acq_active,
    input  logic                        cfg_we,
    input  logic [1:0]                  cfg_sel,
    input  logic [CH_W-1:0]             cfg_chan,
    input  logic [CFG_W-1:0]            cfg_data,
    output logic [NCH-1:0][DT_W-1:0]    holdoff_tab,
    output logic [NCH-1:0][OFS_W-1:0]   skew_tab,
    output logic                        ref_en,
    output logic [CH_W-1:0]             ref_chan
);

    logic wr_ok;
    assign wr_ok = cfg_we && !acq_active;

    for (genvar i = 0; i < NCH; i++) begin : g_chan_cfg
        logic hit_me;
        assign hit_me = wr_ok && (int'(cfg_chan) == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                holdoff_tab[i] <= '0;
                skew_tab[i]    <= '0;
            end else if (hit_me) begin
                if (cfg_sel == CFG_HOLDOFF) holdoff_tab[i] <= cfg_data[DT_W-1:0];
                if (cfg_sel == CFG_SKEW)    skew_tab[i]    <= cfg_data[OFS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_en   <= 1'b0;
            ref_chan <= '0;
        end else if (wr_ok && cfg_sel == CFG_REF) begin
            ref_en   <= cfg_data[CH_W];
            ref_chan <= cfg_data[CH_W-1:0];
        end
    end

endmodule

// File: rtl/tsc_skew_stage.sv
module tsc_skew_stage
    import tsc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int OFS_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hit_valid,
    input  logic [CH_W-1:0]             hit_chan,
    input  ts_t                         hit_time,
    input  logic [NCH-1:0][OFS_W-1:0]   skew_tab,
    output stamp_t                      s_hit,
    output logic [CH_W-1:0]             s_chan
);

    localparam int EXT_W = TS_W - OFS_W;

    logic [OFS_W-1:0] skew_sel;
    ts_t              skew_ext;

    always_comb begin
        skew_sel = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(hit_chan) == i) skew_sel = skew_tab[i];
        end
        skew_ext = {{EXT_W{skew_sel[OFS_W-1]}}, skew_sel};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_hit  <= '0;
            s_chan <= '0;
        end else begin
            s_hit.valid <= hit_valid;
            s_hit.stamp <= hit_time + skew_ext;
            s_chan      <= hit_chan;
        end
    end

endmodule

// File: rtl/tsc_gate_stage.sv
module tsc_gate_stage
    import tsc_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = 3,
    parameter int DT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        run_start,
    input  logic [NCH-1:0][DT_W-1:0]    holdoff_tab,
    input  logic                        ref_en,
    input  logic [CH_W-1:0]             ref_chan,
    input  stamp_t                      s_hit,
    input  logic [CH_W-1:0]             s_chan,
    output logic                        out_valid,
    output logic [CH_W-1:0]             out_chan,
    output ts_t                         out_time
);

    localparam int PAD_W = TS_W - DT_W;

    ts_t             last_kept [NCH];
    logic [NCH-1:0]  have_last;
    ts_t             ref_time;
    logic            ref_seen;

    ts_t             last_sel;
    logic            have_sel;
    logic [DT_W-1:0] window_sel;
    logic            window_ok;
    logic            is_ref;
    logic            emit;
    ts_t             emit_time;

    always_comb begin
        last_sel   = '0;
        have_sel   = 1'b0;
        window_sel = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(s_chan) == i) begin
                last_sel   = last_kept[i];
                have_sel   = have_last[i];
                window_sel = holdoff_tab[i];
            end
        end
        window_ok = !have_sel ||
                    (ts_elapsed(s_hit.stamp, last_sel) >= {{PAD_W{1'b0}}, window_sel});
    end

    always_comb begin
        is_ref    = ref_en && (s_chan == ref_chan);
        emit      = 1'b0;
        emit_time = s_hit.stamp;
        if (s_hit.valid && window_ok) begin
            if (!ref_en) begin
                emit = 1'b1;
            end else if (is_ref) begin
                emit      = 1'b1;
                emit_time = '0;
            end else if (ref_seen) begin
                emit      = 1'b1;
                emit_time = ts_elapsed(s_hit.stamp, ref_time);
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_history
        logic take;
        assign take = s_hit.valid && window_ok && (int'(s_chan) == i);

        always_ff @(posedge clk) begin
            if (rst || run_start) begin
                have_last[i] <= 1'b0;
                last_kept[i] <= '0;
            end else if (take) begin
                have_last[i] <= 1'b1;
                last_kept[i] <= s_hit.stamp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || run_start) begin
            ref_seen <= 1'b0;
            ref_time <= '0;
        end else if (s_hit.valid && window_ok && is_ref) begin
            ref_seen <= 1'b1;
            ref_time <= s_hit.stamp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_time  <= '0;
        end else begin
            out_valid <= emit;
            out_chan  <= s_chan;
            out_time  <= emit_time;
        end
    end

endmodule

// File: rtl/tsc_conditioner.sv
module tsc_conditioner
    import tsc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int DT_W  = 16,
    parameter int OFS_W = 16,
    localparam int CFG_W = max3(DT_W, OFS_W, CH_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_active,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [TS_W-1:0]   in_time,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_chan,
    output logic [TS_W-1:0]   out_time
);

    logic                       acq_q;
    logic                       run_start;
    logic                       hit_valid;
    logic [NCH-1:0][DT_W-1:0]   holdoff_tab;
    logic [NCH-1:0][OFS_W-1:0]  skew_tab;
    logic                       ref_en;
    logic [CH_W-1:0]            ref_chan;
    stamp_t                     s_hit;
    logic [CH_W-1:0]            s_chan;

    always_ff @(posedge clk) begin
        if (rst) acq_q <= 1'b0;
        else     acq_q <= acq_active;
    end

    assign run_start = acq_active && !acq_q;
    assign hit_valid = in_valid && acq_active;

    tsc_cfg_bank #(
        .NCH(NCH), .CH_W(CH_W), .DT_W(DT_W), .OFS_W(OFS_W), .CFG_W(CFG_W)
    ) i_cfg (
        .clk         (clk),
        .rst         (rst),
        .acq_active  (acq_active),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_chan    (cfg_chan),
        .cfg_data    (cfg_data),
        .holdoff_tab (holdoff_tab),
        .skew_tab    (skew_tab),
        .ref_en      (ref_en),
        .ref_chan    (ref_chan)
    );

    tsc_skew_stage #(
        .NCH(NCH), .CH_W(CH_W), .OFS_W(OFS_W)
    ) i_skew (
        .clk       (clk),
        .rst       (rst),
        .hit_valid (hit_valid),
        .hit_chan  (in_chan),
        .hit_time  (in_time),
        .skew_tab  (skew_tab),
        .s_hit     (s_hit),
        .s_chan    (s_chan)
    );

    tsc_gate_stage #(
        .NCH(NCH), .CH_W(CH_W), .DT_W(DT_W)
    ) i_gate (
        .clk         (clk),
        .rst         (rst),
        .run_start   (run_start),
        .holdoff_tab (holdoff_tab),
        .ref_en      (ref_en),
        .ref_chan    (ref_chan),
        .s_hit       (s_hit),
        .s_chan      (s_chan),
        .out_valid   (out_valid),
        .out_chan    (out_chan),
        .out_time    (out_time)
    );

endmodule

// File: rtl/tsc_conditioner_chk.sv
module tsc_conditioner_chk
    import tsc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int DT_W  = 16,
    parameter int OFS_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       acq_active,
    input logic                       in_valid,
    input logic [CH_W-1:0]            in_chan,
    input logic [NCH-1:0][DT_W-1:0]   holdoff_tab,
    input logic [NCH-1:0][OFS_W-1:0]  skew_tab,
    input logic                       ref_en,
    input logic [CH_W-1:0]            ref_chan,
    input logic                       out_valid,
    input logic [CH_W-1:0]            out_chan,
    input logic [TS_W-1:0]            out_time
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: every output comes from an accepted input two edges earlier
    a_r1_has_origin: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid) |-> $past(in_valid && acq_active, 2));

    // R1: the channel tag travels unchanged
    a_r1_chan_kept: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid) |-> (out_chan == $past(in_chan, 2)));

    // R2: nothing leaves the block for a hit offered while idle
    a_r2_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !$past(acq_active, 2)) |-> !out_valid);

    // R8: a reference-channel hit is reported at zero
    a_r8_ref_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ref_en && out_chan == ref_chan) |-> (out_time == '0));

    // R10: configuration is frozen while a run is active
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        acq_active |=> ($stable(holdoff_tab) && $stable(skew_tab) &&
                        $stable(ref_en) && $stable(ref_chan)));

endmodule

bind tsc_conditioner tsc_conditioner_chk #(
    .NCH(NCH), .CH_W(CH_W), .DT_W(DT_W), .OFS_W(OFS_W)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .acq_active  (acq_active),
    .in_valid    (in_valid),
    .in_chan     (in_chan),
    .holdoff_tab (holdoff_tab),
    .skew_tab    (skew_tab),
    .ref_en      (ref_en),
    .ref_chan    (ref_chan),
    .out_valid   (out_valid),
    .out_chan    (out_chan),
    .out_time    (out_time)
);

// File: tb/test_tsc_conditioner.sv
module test_tsc_conditioner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_active = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_chan = '0;
    logic [55:0] in_time = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_chan = '0;
    logic [15:0] cfg_data = '0;
    logic        out_valid;
    logic [2:0]  out_chan;
    logic [55:0] out_time;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct packed {
        logic [2:0]  ch;
        logic [55:0] t;
    } rec_t;

    rec_t got[$];
    bit   recording = 1'b0;

    always #5 clk = ~clk;

    tsc_conditioner i_tsc_conditioner (
        .clk(clk), .rst(rst), .acq_active(acq_active),
        .in_valid(in_valid), .in_chan(in_chan), .in_time(in_time),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_chan(cfg_chan), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_chan(out_chan), .out_time(out_time)
    );

    always @(negedge clk) begin
        if (recording && out_valid) got.push_back({out_chan, out_time});
    end

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_rec(string req, int idx, logic [2:0] ch, logic [55:0] t);
        if (idx >= got.size()) begin
            n_checks++;
            n_fails++;
            $display("FAIL %s record %0d: actual missing expected ch%0d t=%0d", req, idx, ch, t);
        end else begin
            check(req, $sformatf("record %0d channel", idx), 64'(got[idx].ch), 64'(ch));
            check(req, $sformatf("record %0d time", idx), 64'(got[idx].t), 64'(t));
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [2:0] ch, logic [15:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_chan = ch; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic hit(logic [2:0] ch, logic [55:0] t);
        in_valid = 1'b1; in_chan = ch; in_time = t;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic start_run();
        got.delete();
        recording = 1'b1;
        acq_active = 1'b1;
        ticks(2);
    endtask

    task automatic stop_run();
        ticks(3);
        acq_active = 1'b0;
        ticks(2);
        recording = 1'b0;
    endtask

    task automatic t_reset_defaults();
        check("R12", "out_valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        ticks(1);
        start_run();
        hit(3'd2, 56'd100);
        stop_run();
        check("R12", "record count", 64'(got.size()), 64'd1);
        check_rec("R12", 0, 3'd2, 56'd100);
    endtask

    task automatic t_latency();
        acq_active = 1'b1;
        ticks(2);
        in_valid = 1'b1; in_chan = 3'd4; in_time = 56'd7;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "out_valid after one edge", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R1", "out_valid after two edges", 64'(out_valid), 64'd1);
        check("R1", "channel", 64'(out_chan), 64'd4);
        check("R1", "time", 64'(out_time), 64'd7);
        acq_active = 1'b0;
        ticks(3);
    endtask

    task automatic t_idle_ignored();
        got.delete();
        recording = 1'b1;
        hit(3'd1, 56'd9);
        ticks(4);
        recording = 1'b0;
        check("R2", "records while idle", 64'(got.size()), 64'd0);
    endtask

    task automatic t_skew();
        cfg_write(2'd1, 3'd1, 16'hFFFB);
        cfg_write(2'd1, 3'd3, 16'd7);
        start_run();
        hit(3'd1, 56'd100);
        hit(3'd3, 56'd100);
        hit(3'd1, 56'd2);
        stop_run();
        check("R3", "record count", 64'(got.size()), 64'd3);
        check_rec("R3", 0, 3'd1, 56'd95);
        check_rec("R3", 1, 3'd3, 56'd107);
        check_rec("R7", 2, 3'd1, 56'd2 - 56'd5);
    endtask

    task automatic t_holdoff_and_lock();
        cfg_write(2'd0, 3'd0, 16'd10);
        start_run();
        hit(3'd0, 56'd1000);
        hit(3'd0, 56'd1005);
        hit(3'd4, 56'd1006);
        hit(3'd0, 56'd1012);
        hit(3'd0, 56'd1022);
        hit(3'd0, 56'd1031);
        ticks(3);
        check("R4", "record count", 64'(got.size()), 64'd4);
        check_rec("R4", 0, 3'd0, 56'd1000);
        check_rec("R6", 1, 3'd4, 56'd1006);
        check_rec("R5", 2, 3'd0, 56'd1012);
        check_rec("R4", 3, 3'd0, 56'd1022);
        got.delete();
        cfg_write(2'd1, 3'd0, 16'd100);
        cfg_write(2'd0, 3'd0, 16'd0);
        hit(3'd0, 56'd1035);
        hit(3'd0, 56'd1040);
        stop_run();
        check("R10", "record count", 64'(got.size()), 64'd1);
        check_rec("R10", 0, 3'd0, 56'd1035);
    endtask

    task automatic t_restart();
        start_run();
        hit(3'd0, 56'd1037);
        stop_run();
        check("R11", "record count", 64'(got.size()), 64'd1);
        check_rec("R11", 0, 3'd0, 56'd1037);
    endtask

    task automatic t_reference();
        cfg_write(2'd2, 3'd0, 16'h000D);
        start_run();
        hit(3'd2, 56'd50);
        hit(3'd5, 56'd100);
        hit(3'd2, 56'd130);
        hit(3'd6, 56'd90);
        hit(3'd5, 56'd200);
        hit(3'd2, 56'd250);
        stop_run();
        check("R9", "record count", 64'(got.size()), 64'd5);
        check_rec("R8", 0, 3'd5, 56'd0);
        check_rec("R8", 1, 3'd2, 56'd30);
        check_rec("R8", 2, 3'd6, 56'd90 - 56'd100);
        check_rec("R8", 3, 3'd5, 56'd0);
        check_rec("R8", 4, 3'd2, 56'd50);
        start_run();
        hit(3'd2, 56'd300);
        stop_run();
        check("R9", "hit before reference in new run", 64'(got.size()), 64'd0);
        cfg_write(2'd2, 3'd0, 16'h0000);
        start_run();
        hit(3'd2, 56'd300);
        stop_run();
        check("R7", "record count", 64'(got.size()), 64'd1);
        check_rec("R7", 0, 3'd2, 56'd300);
    endtask

    initial begin
        ticks(3);
        t_reset_defaults();
        t_latency();
        t_idle_ignored();
        t_skew();
        t_holdoff_and_lock();
        t_restart();
        t_reference();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule